// File: doc/BRIEF.md
# Multi-rail supply fault supervisor

This block supervises the main rails of a multi-rail supply. Analog comparators outside the block watch the rails and deliver digital flags. The flags cover over-current and over-voltage on the 3.3 V, 5 V and 12 V rails, under-voltage on the 12 V rail, and "above threshold" indications for a power-good input, the 3.3 V rail and the 5 V rail. An active-low on/off request from the host decides whether the main rails should run. The block filters each fault flag over a qualification time that depends on its class. It latches the first qualified fault and drives a fault-protect output: while that output is high, the main rails are kept off. It also produces a power-good output that asserts only after a long delay and drops without delay.

The on/off request is debounced in both directions. A latched fault can be cleared only by a debounced turn-off edge of the request, or by reset. Reset stands for removal of the supply. While the rails ramp after a turn-on, 12 V under-voltage detection is masked. The mask ends when power-good first asserts, or when a timeout runs out. All times are cycle counts. Their defaults are derived from a clock-frequency parameter, and a user may override each of them.

Top module: `psup_supervisor`

## Requirements
- R1: An over-current or over-voltage flag (bit 0 = 3.3 V, bit 1 = 5 V, bit 2 = 12 V) qualifies as a fault once it has been high for OC_CYC consecutive cycles while the rails are on. The latch sets on the OC_CYC-th rising clock edge. A shorter pulse has no effect, and the count restarts from zero whenever the flag drops.
- R2: The 12 V under-voltage flag qualifies as a fault after UV_CYC consecutive cycles while the rails are on and the under-voltage mask is inactive.
- R3: When a fault qualifies, fault_o rises and pgood_o falls on the same clock edge.
- R4: A latched fault, and fault_o with it, stays set until the debounced request goes from on to off. An asserted rst_ni also clears it. A request glitch shorter than DEB_CYC cycles does not clear it.
- R5: While the debounced request is off (onoff_ni high), fault_o is high, and fault flags have no effect on cause_o.
- R6: A change of onoff_ni takes effect only after the new level has been held for DEB_CYC consecutive cycles, in either direction. After reset the debounced request reads off.
- R7: From the debounced turn-on edge, 12 V under-voltage detection is masked. The mask ends at the first cycle in which pgood_o is high, or after MASK_CYC cycles, whichever comes first.
- R8: pgood_o rises PG_CYC cycles after all three bits of rail_ok_i are high and fault_o is low, provided both conditions hold throughout.
- R9: pgood_o falls in the same cycle that any bit of rail_ok_i falls. A later recovery restarts the full PG_CYC delay.
- R10: cause_o reports the class of the first fault: 0 none, 1 over-current, 2 over-voltage, 3 12 V under-voltage. Within one cycle, over-current wins over over-voltage, and over-voltage wins over under-voltage. The value holds while the fault stays latched and returns to 0 when the latch clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (supply removal) |
| onoff_ni | input | 1 | Remote on/off request, low = rails on, synchronous to clk_i |
| oc_i | input | 3 | Over-current flags, bit 0 = 3.3 V, 1 = 5 V, 2 = 12 V |
| ov_i | input | 3 | Over-voltage flags, same bit order |
| uv12_i | input | 1 | 12 V under-voltage flag |
| rail_ok_i | input | 3 | Above-threshold flags: bit 0 power-good input, bit 1 3.3 V, bit 2 5 V |
| fault_o | output | 1 | Fault-protect output, high = main rails off |
| pgood_o | output | 1 | Power-good output |
| cause_o | output | 2 | Class of the latched fault |

## Verification
The checker watches, on every cycle, the relations that hold at every instant. pgood_o is never high together with fault_o, and never high unless all rail_ok_i bits are high. pgood_o never rises without the rails having been good one cycle before. fault_o only drops after the request was sampled on. cause_o is never nonzero without fault_o, and once nonzero it can only hold or clear. The exact qualification, debounce and power-good delays, and the rule that shorter pulses are ignored, are shown only by the bench. The same goes for the ends of the under-voltage mask, the first-fault and priority ordering, and the clearing of the latch. The bench sweeps pulse lengths across each threshold for every over-current and over-voltage flag and samples at the predicted edges.

// File: rtl/psup_pkg.sv
package psup_pkg;
  localparam int NRAIL = 3;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_OC   = 2'd1,
    CAUSE_OV   = 2'd2,
    CAUSE_UV   = 2'd3
  } cause_e;
endpackage

// File: rtl/psup_qual.sv
// Qualifies a flag after N consecutive enabled cycles.
module psup_qual #(
  parameter int N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic flag_i,
  output logic hit_o
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || !flag_i)  cnt_q <= '0;
    else if (cnt_q != LAST)     cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = en_i & flag_i & (cnt_q == LAST);
endmodule

// File: rtl/psup_debounce.sv
// Level follows raw_i after N cycles of disagreement; reset level is high.
module psup_debounce #(
  parameter int N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;
  logic          chg, done;

  assign chg  = raw_i ^ lvl_q;
  assign done = chg & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (!chg) begin
      cnt_q <= '0;
    end else if (done) begin
      cnt_q <= '0;
      lvl_q <= raw_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = done & raw_i;
  assign fall_o = done & ~raw_i;
endmodule

// File: rtl/psup_pgdelay.sv
// Slow assert, immediate deassert.
module psup_pgdelay #(
  parameter int N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ok_i,
  output logic pg_o
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q;
  logic          pg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pg_q  <= 1'b0;
    end else if (!ok_i) begin
      cnt_q <= '0;
      pg_q  <= 1'b0;
    end else if (cnt_q == LAST) begin
      pg_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pg_o = pg_q & ok_i;
endmodule

// File: rtl/psup_supervisor.sv
module psup_supervisor
  import psup_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int OC_CYC   = (CLK_HZ / 1_000_000) * 73,
  parameter int UV_CYC   = (CLK_HZ / 1_000_000) * 150,
  parameter int DEB_CYC  = (CLK_HZ / 1_000) * 38,
  parameter int PG_CYC   = (CLK_HZ / 1_000) * 300,
  parameter int MASK_CYC = (CLK_HZ / 1_000) * 500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             onoff_ni,
  input  logic [NRAIL-1:0] oc_i,
  input  logic [NRAIL-1:0] ov_i,
  input  logic             uv12_i,
  input  logic [NRAIL-1:0] rail_ok_i,
  output logic             fault_o,
  output logic             pgood_o,
  output logic [1:0]       cause_o
);
  localparam int MW = $clog2(MASK_CYC + 1);
  localparam logic [MW-1:0] MLAST = MW'(MASK_CYC - 1);

  logic               off_lvl, req_rise, req_fall;
  logic [2*NRAIL-1:0] fast_flag, fast_hit;
  logic               uv_hit, oc_hit, ov_hit;
  logic               mask_q;
  logic [MW-1:0]      mcnt_q;
  logic               lat_q;
  cause_e             cause_q;

  psup_debounce #(.N(DEB_CYC)) u_deb (
    .clk_i, .rst_ni, .raw_i(onoff_ni),
    .lvl_o(off_lvl), .rise_o(req_rise), .fall_o(req_fall)
  );

  assign fast_flag = {ov_i, oc_i};

  for (genvar g = 0; g < 2*NRAIL; g++) begin : g_fast
    psup_qual #(.N(OC_CYC)) u_q (
      .clk_i, .rst_ni, .en_i(~off_lvl),
      .flag_i(fast_flag[g]), .hit_o(fast_hit[g])
    );
  end

  psup_qual #(.N(UV_CYC)) u_uv (
    .clk_i, .rst_ni, .en_i(~off_lvl & ~mask_q),
    .flag_i(uv12_i), .hit_o(uv_hit)
  );

  assign oc_hit = |fast_hit[NRAIL-1:0];
  assign ov_hit = |fast_hit[2*NRAIL-1:NRAIL];

  // turn-on under-voltage mask
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b0;
      mcnt_q <= '0;
    end else if (req_fall) begin
      mask_q <= 1'b1;
      mcnt_q <= '0;
    end else if (off_lvl || pgood_o || (mask_q && mcnt_q == MLAST)) begin
      mask_q <= 1'b0;
      mcnt_q <= '0;
    end else if (mask_q) begin
      mcnt_q <= mcnt_q + 1'b1;
    end
  end

  // fault latch, first cause wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else if (req_rise) begin
      lat_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else if (!lat_q && (oc_hit || ov_hit || uv_hit)) begin
      lat_q   <= 1'b1;
      cause_q <= oc_hit ? CAUSE_OC : (ov_hit ? CAUSE_OV : CAUSE_UV);
    end
  end

  assign fault_o = off_lvl | lat_q;
  assign cause_o = cause_q;

  psup_pgdelay #(.N(PG_CYC)) u_pg (
    .clk_i, .rst_ni, .ok_i((&rail_ok_i) & ~fault_o), .pg_o(pgood_o)
  );
endmodule

// File: rtl/psup_supervisor_chk.sv
module psup_supervisor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       onoff_ni,
  input logic [2:0] rail_ok_i,
  input logic       fault_o,
  input logic       pgood_o,
  input logic [1:0] cause_o
);
  // R3
  pg_vs_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgood_o |-> !fault_o);

  // R9
  pg_rails_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgood_o |-> (&rail_ok_i));

  // R8
  pg_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgood_o) |-> $past(&rail_ok_i));

  // R6
  fault_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o) |-> $past(!onoff_ni));

  // R10
  cause_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o != 2'd0) |-> fault_o);

  // R10
  cause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o != 2'd0) |=> (cause_o == $past(cause_o) || cause_o == 2'd0));
endmodule

bind psup_supervisor psup_supervisor_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .onoff_ni(onoff_ni), .rail_ok_i(rail_ok_i),
  .fault_o(fault_o), .pgood_o(pgood_o), .cause_o(cause_o)
);

// File: tb/psup_supervisor_tb_top.sv
`timescale 1ns/1ps
module psup_supervisor_tb_top;
  localparam int OC = 4, UV = 7, DEB = 5, PG = 6, MSK = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       onoff_n = 1'b1;
  logic [2:0] oc = '0, ov = '0, ok = '0;
  logic       uv12 = 1'b0;
  logic       fault, pgood;
  logic [1:0] cause;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  psup_supervisor #(.OC_CYC(OC), .UV_CYC(UV), .DEB_CYC(DEB), .PG_CYC(PG), .MASK_CYC(MSK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .onoff_ni(onoff_n), .oc_i(oc), .ov_i(ov),
    .uv12_i(uv12), .rail_ok_i(ok), .fault_o(fault), .pgood_o(pgood), .cause_o(cause)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_on();
    onoff_n = 1'b0; tick(DEB);
  endtask

  task automatic go_off();
    onoff_n = 1'b1; tick(DEB);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R6 reset fault_o", fault, 1);
    chk("R8 reset pgood_o", pgood, 0);
    chk("R10 reset cause_o", cause, 0);
    rst_n = 1'b1;
    tick(2);

    // R6: short turn-on request ignored
    onoff_n = 1'b0; tick(DEB - 1); onoff_n = 1'b1; tick(DEB + 2);
    chk("R6 short on glitch", fault, 1);

    // R6/R8: turn on with rails good
    ok = 3'b111;
    onoff_n = 1'b0; tick(DEB - 1);
    chk("R6 on edge minus one", fault, 1);
    tick(1);
    chk("R6 on edge", fault, 0);
    tick(PG - 1);
    chk("R8 pgood before delay", pgood, 0);
    tick(1);
    chk("R8 pgood at delay", pgood, 1);
    tick(1);
    // R7: mask gone after pgood; R2 threshold
    uv12 = 1'b1; tick(UV - 1);
    chk("R2 uv short", fault, 0);
    uv12 = 1'b0; tick(1);
    uv12 = 1'b1; tick(UV);
    chk("R7 R2 uv trips after pgood", fault, 1);
    chk("R3 pgood drops with fault", pgood, 0);
    chk("R10 uv cause", cause, 3);
    uv12 = 1'b0;

    // R4: short off glitch does not clear
    onoff_n = 1'b1; tick(DEB - 1); onoff_n = 1'b0; tick(DEB + 2);
    chk("R4 glitch keeps fault", fault, 1);
    chk("R4 glitch keeps cause", cause, 3);

    // R4/R5: debounced off clears latch, off ignores flags
    go_off();
    chk("R4 cleared cause", cause, 0);
    chk("R5 off holds fault_o", fault, 1);
    oc[2] = 1'b1; ov[0] = 1'b1; tick(OC * 3);
    chk("R5 flags ignored when off", cause, 0);
    oc = '0; ov = '0;
    go_on(); tick(PG);
    chk("R8 pgood after re-on", pgood, 1);

    // R9: each rail drops pgood at once
    for (int b = 0; b < 3; b++) begin
      ok[b] = 1'b0; #1;
      chk($sformatf("R9 drop bit %0d", b), pgood, 0);
      tick(1); ok[b] = 1'b1;
      tick(PG - 1);
      chk($sformatf("R9 restart bit %0d early", b), pgood, 0);
      tick(1);
      chk($sformatf("R9 restart bit %0d", b), pgood, 1);
    end

    // R1: pulse-length sweep on all OC/OV flags
    for (int g = 0; g < 6; g++) begin
      for (int len = 1; len <= OC + 1; len++) begin
        bit trip;
        trip = (len >= OC);
        if (g < 3) oc[g] = 1'b1; else ov[g-3] = 1'b1;
        tick(len);
        chk($sformatf("R1 flag %0d len %0d fault", g, len), fault, trip);
        chk($sformatf("R3 flag %0d len %0d pgood", g, len), pgood, !trip);
        oc = '0; ov = '0;
        tick(1);
        if (trip) begin
          tick(2);
          chk($sformatf("R4 flag %0d latched", g), fault, 1);
          chk($sformatf("R10 flag %0d cause", g), cause, (g < 3) ? 1 : 2);
          go_off(); go_on(); tick(PG);
        end
      end
    end

    // R10: same-cycle priority and first-wins
    oc[0] = 1'b1; ov[0] = 1'b1; tick(OC);
    chk("R10 oc over ov", cause, 1);
    oc = '0; ov = '0; go_off(); go_on(); tick(PG);
    ov[1] = 1'b1; tick(OC);
    chk("R10 ov first", cause, 2);
    oc[1] = 1'b1; tick(OC + 1);
    chk("R10 first cause kept", cause, 2);
    oc = '0; ov = '0; go_off();

    // R7: mask until timeout without pgood
    ok = 3'b000; uv12 = 1'b1;
    go_on(); tick(MSK - 1);
    chk("R7 masked at ramp", fault, 0);
    tick(UV);
    chk("R7 R2 uv after timeout minus one", fault, 0);
    tick(1);
    chk("R7 R2 uv after timeout", fault, 1);
    chk("R10 uv cause timeout", cause, 3);
    uv12 = 1'b0;

    // R4: reset clears latch
    rst_n = 1'b0; tick(1);
    chk("R4 reset cause", cause, 0);
    chk("R6 reset off", fault, 1);
    rst_n = 1'b1; tick(DEB);
    chk("R6 on after reset", fault, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule